// File: doc/BRIEF.md
# Extended-State Save Fault Gate

This block decides, before an extended processor-state save is allowed to write memory, whether the request has to be turned away with a fault and which one. The pipeline presents a request strobe together with the operand effective address, the current execution mode, and the control and status flags that bear on the instruction: the feature-present flag, the OS-enable control bit, the task-switched control bit, four prefix-present flags, a segment-limit violation indication and a stack-segment reference flag.

One clock after each request the block returns a registered fault code with a valid strobe. Several faults can be raised by the same request. The block always reports only the most urgent one, in this order: undefined opcode, then device not available, then stack fault, then general protection. The operand must start on a 64-byte boundary in every mode. The block also applies one address rule that depends on the mode: a 16-bit range check in real mode, a segment-limit check in protected mode and a canonical-form check in 64-bit mode. The block computes the canonical form and the real-mode range from the address itself. The segment-limit violation is an input.

Top module: `ext_save_fault_chk`

## Requirements
- R1: `fault_vld_o` is 1 in exactly the cycle after a cycle with `req_i` = 1. In every other cycle, and after reset, `fault_vld_o` is 0 and `fault_code_o` is 0.
- R2: A request with `feat_present_i` = 0 reports code 1 (undefined opcode).
- R3: A request with `os_enable_i` = 0 reports code 1.
- R4: A request with any bit of `pfx_i` set reports code 1. The bits of `pfx_i` are: bit 0 lock, bit 1 operand-size, bit 2 repeat, bit 3 repeat-not-equal.
- R5: A request with `task_sw_i` = 1 and no undefined-opcode cause reports code 2 (device not available).
- R6: When no higher-priority cause is present, a request whose address has any of bits [5:0] nonzero reports code 4 (general protection) in every mode.
- R7: In real mode, a request reports code 4 if `ea_i` + 575 (the last byte of the 576-byte area) exceeds 0xFFFF. The sum is taken without wrap-around.
- R8: In 64-bit mode an address is non-canonical when bits [63:47] are not all equal. A non-canonical address reports code 3 (stack fault) if `stack_ref_i` = 1, and code 4 otherwise.
- R9: In protected mode, `limit_viol_i` = 1 reports code 3 if `stack_ref_i` = 1, and code 4 otherwise.
- R10: The codes are 0 none, 1 undefined opcode, 2 device not available, 3 stack fault, 4 general protection. Priority runs 1 > 2 > 3 > 4, and only the highest-priority code is reported.
- R11: The mode encoding on `mode_i` is 0 real, 1 protected, 2 64-bit. Value 3 is handled exactly like protected mode.
- R12: Inputs that do not apply to the current mode have no effect. `limit_viol_i` is ignored in real and 64-bit mode. Canonical form is ignored outside 64-bit mode. `stack_ref_i` never produces a stack fault in real mode.
- R13: A request with no fault cause reports code 0 with `fault_vld_o` = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_i | input | 1 | Check request strobe |
| ea_i | input | 64 | Operand effective address |
| mode_i | input | 2 | 0 real, 1 protected, 2 64-bit, 3 treated as protected |
| feat_present_i | input | 1 | Save feature is implemented |
| os_enable_i | input | 1 | OS has enabled extended-state saves |
| task_sw_i | input | 1 | Task-switched control bit |
| pfx_i | input | 4 | Prefix present flags: lock, operand-size, repeat, repeat-not-equal |
| limit_viol_i | input | 1 | Segment-limit violation (protected mode) |
| stack_ref_i | input | 1 | Reference goes through the stack segment |
| fault_vld_o | output | 1 | Result valid, one cycle after request |
| fault_code_o | output | 3 | Fault code, 0 when not valid |

## Verification
The assertions treat each request cycle as independent. They assume that the inputs are stable around the rising edge and are meaningful only in cycles where `req_i` is high. They assume nothing about how far apart requests are, so back-to-back requests are also allowed. The stimulus drives all inputs on the falling edge and leaves one idle cycle after each request. The idle cycle lets the bench check both the result and the return to code 0. Random addresses are drawn from a small set of classes: a low 16-bit range, a sign-extended canonical address, a deliberately non-canonical address and a fully random address. Alignment is cleared half of the time. This biasing makes every mode rule and every priority pair occur often.

// File: rtl/esf_pkg.sv
package esf_pkg;

  typedef enum logic [2:0] {
    FLT_NONE = 3'd0,
    FLT_UD   = 3'd1,
    FLT_NM   = 3'd2,
    FLT_SS   = 3'd3,
    FLT_GP   = 3'd4
  } flt_e;

  typedef enum logic [1:0] {
    MODE_REAL = 2'd0,
    MODE_PROT = 2'd1,
    MODE_LONG = 2'd2,
    MODE_RSVD = 2'd3
  } mode_e;

endpackage

// File: rtl/esf_opcode_chk.sv
module esf_opcode_chk #(
  parameter int PFX_N = 4
) (
  input  logic             feat_i,
  input  logic             os_en_i,
  input  logic [PFX_N-1:0] pfx_i,
  output logic             ud_o
);
  logic any_pfx;

  // Any disallowed prefix, the feature missing or OS support off all
  // make the instruction undefined.
  assign any_pfx = |pfx_i;
  assign ud_o    = ~feat_i | ~os_en_i | any_pfx;

endmodule

// File: rtl/esf_addr_chk.sv
module esf_addr_chk
  import esf_pkg::*;
#(
  parameter int          ADDR_W     = 64,
  parameter int          VA_W       = 48,
  parameter int          ALIGN_LG2  = 6,
  parameter int          AREA_BYTES = 576,
  parameter logic [31:0] REAL_LIMIT = 32'h0000_FFFF
) (
  input  logic [ADDR_W-1:0] ea_i,
  input  mode_e             mode_i,
  input  logic              limit_viol_i,
  input  logic              stack_ref_i,
  output logic              ss_o,
  output logic              gp_o
);
  localparam int SUM_W = ADDR_W + 1;

  logic             misaligned;
  logic             canon;
  logic [SUM_W-1:0] last_byte;
  logic             real_oob;
  logic             addr_bad;

  assign misaligned = |ea_i[ALIGN_LG2-1:0];

  // Canonical form: every bit above the implemented width copies the top
  // implemented bit. With a full-width address every value is canonical.
  generate
    if (VA_W < ADDR_W) begin : g_canon
      logic [ADDR_W-VA_W:0] hi_bits;
      assign hi_bits = ea_i[ADDR_W-1:VA_W-1];
      assign canon   = (&hi_bits) | ~(|hi_bits);
    end else begin : g_full
      assign canon = 1'b1;
    end
  endgenerate

  // Real-mode range: the last byte of the area must not pass the limit.
  assign last_byte = {1'b0, ea_i} + SUM_W'(AREA_BYTES - 1);
  assign real_oob  = last_byte > SUM_W'(REAL_LIMIT);

  always_comb begin
    unique case (mode_i)
      MODE_REAL: addr_bad = real_oob;
      MODE_LONG: addr_bad = ~canon;
      default:   addr_bad = limit_viol_i;
    endcase
  end

  // A bad stack-segment reference becomes a stack fault outside real mode.
  assign ss_o = addr_bad & stack_ref_i & (mode_i != MODE_REAL);
  assign gp_o = misaligned | (addr_bad & ~ss_o);

endmodule

// File: rtl/esf_prio.sv
module esf_prio
  import esf_pkg::*;
(
  input  logic ud_i,
  input  logic nm_i,
  input  logic ss_i,
  input  logic gp_i,
  output flt_e code_o
);
  always_comb begin
    if (ud_i)      code_o = FLT_UD;
    else if (nm_i) code_o = FLT_NM;
    else if (ss_i) code_o = FLT_SS;
    else if (gp_i) code_o = FLT_GP;
    else           code_o = FLT_NONE;
  end
endmodule

// File: rtl/ext_save_fault_chk.sv
module ext_save_fault_chk
  import esf_pkg::*;
#(
  parameter int          ADDR_W     = 64,
  parameter int          VA_W       = 48,
  parameter int          ALIGN_LG2  = 6,
  parameter int          AREA_BYTES = 576,
  parameter logic [31:0] REAL_LIMIT = 32'h0000_FFFF,
  parameter int          PFX_N      = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_i,
  input  logic [ADDR_W-1:0] ea_i,
  input  logic [1:0]        mode_i,
  input  logic              feat_present_i,
  input  logic              os_enable_i,
  input  logic              task_sw_i,
  input  logic [PFX_N-1:0]  pfx_i,
  input  logic              limit_viol_i,
  input  logic              stack_ref_i,
  output logic              fault_vld_o,
  output logic [2:0]        fault_code_o
);
  logic  ud_hit;
  logic  ss_hit;
  logic  gp_hit;
  flt_e  next_code;
  flt_e  code_q;
  logic  vld_q;
  mode_e mode;

  assign mode = mode_e'(mode_i);

  esf_opcode_chk #(.PFX_N(PFX_N)) u_op (
    .feat_i  (feat_present_i),
    .os_en_i (os_enable_i),
    .pfx_i   (pfx_i),
    .ud_o    (ud_hit)
  );

  esf_addr_chk #(
    .ADDR_W    (ADDR_W),
    .VA_W      (VA_W),
    .ALIGN_LG2 (ALIGN_LG2),
    .AREA_BYTES(AREA_BYTES),
    .REAL_LIMIT(REAL_LIMIT)
  ) u_addr (
    .ea_i        (ea_i),
    .mode_i      (mode),
    .limit_viol_i(limit_viol_i),
    .stack_ref_i (stack_ref_i),
    .ss_o        (ss_hit),
    .gp_o        (gp_hit)
  );

  esf_prio u_prio (
    .ud_i  (ud_hit),
    .nm_i  (task_sw_i),
    .ss_i  (ss_hit),
    .gp_i  (gp_hit),
    .code_o(next_code)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      vld_q  <= 1'b0;
      code_q <= FLT_NONE;
    end else begin
      vld_q  <= req_i;
      code_q <= req_i ? next_code : FLT_NONE;
    end
  end

  assign fault_vld_o  = vld_q;
  assign fault_code_o = code_q;

endmodule

// File: rtl/esf_checker.sv
module esf_checker #(
  parameter int ADDR_W = 64,
  parameter int PFX_N  = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              req_i,
  input logic [ADDR_W-1:0] ea_i,
  input logic [1:0]        mode_i,
  input logic              feat_present_i,
  input logic              os_enable_i,
  input logic              task_sw_i,
  input logic [PFX_N-1:0]  pfx_i,
  input logic              stack_ref_i,
  input logic              fault_vld_o,
  input logic [2:0]        fault_code_o
);
  logic no_ud;
  assign no_ud = feat_present_i && os_enable_i && (pfx_i == '0);

  p_vld_after_req_r1: assert property (@(posedge clk) disable iff (rst)
    req_i |=> fault_vld_o);
  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (rst)
    !req_i |=> (!fault_vld_o && fault_code_o == 3'd0));
  p_ud_feat_r2: assert property (@(posedge clk) disable iff (rst)
    (req_i && !feat_present_i) |=> fault_code_o == 3'd1);
  p_ud_os_r3: assert property (@(posedge clk) disable iff (rst)
    (req_i && !os_enable_i) |=> fault_code_o == 3'd1);
  p_ud_pfx_r4: assert property (@(posedge clk) disable iff (rst)
    (req_i && (pfx_i != '0)) |=> fault_code_o == 3'd1);
  p_nm_r5: assert property (@(posedge clk) disable iff (rst)
    (req_i && no_ud && task_sw_i) |=> fault_code_o == 3'd2);
  p_gp_align_r6: assert property (@(posedge clk) disable iff (rst)
    (req_i && no_ud && !task_sw_i && (ea_i[5:0] != 6'd0) && !stack_ref_i)
      |=> fault_code_o == 3'd4);
  p_code_range_r10: assert property (@(posedge clk) disable iff (rst)
    fault_vld_o |-> fault_code_o <= 3'd4);
  p_real_no_ss_r12: assert property (@(posedge clk) disable iff (rst)
    (req_i && mode_i == 2'd0) |=> fault_code_o != 3'd3);
endmodule

bind ext_save_fault_chk esf_checker #(.ADDR_W(ADDR_W), .PFX_N(PFX_N)) u_chk (
  .clk           (clk),
  .rst           (rst),
  .req_i         (req_i),
  .ea_i          (ea_i),
  .mode_i        (mode_i),
  .feat_present_i(feat_present_i),
  .os_enable_i   (os_enable_i),
  .task_sw_i     (task_sw_i),
  .pfx_i         (pfx_i),
  .stack_ref_i   (stack_ref_i),
  .fault_vld_o   (fault_vld_o),
  .fault_code_o  (fault_code_o)
);

// File: tb/sim_ext_save_fault_chk.sv
module sim_ext_save_fault_chk;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_i = 1'b0;
  logic [63:0] ea_i = '0;
  logic [1:0]  mode_i = '0;
  logic        feat_present_i = 1'b1;
  logic        os_enable_i = 1'b1;
  logic        task_sw_i = 1'b0;
  logic [3:0]  pfx_i = '0;
  logic        limit_viol_i = 1'b0;
  logic        stack_ref_i = 1'b0;
  logic        fault_vld_o;
  logic [2:0]  fault_code_o;

  int checks = 0;
  int failures = 0;
  int cyc = 0;

  always #4 clk = ~clk;

  ext_save_fault_chk u0 (
    .clk(clk), .rst(rst), .req_i(req_i), .ea_i(ea_i), .mode_i(mode_i),
    .feat_present_i(feat_present_i), .os_enable_i(os_enable_i),
    .task_sw_i(task_sw_i), .pfx_i(pfx_i), .limit_viol_i(limit_viol_i),
    .stack_ref_i(stack_ref_i), .fault_vld_o(fault_vld_o),
    .fault_code_o(fault_code_o)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 100000) begin
      failures = failures + 1;
      $display("FAIL watchdog: run did not finish, actual cycles=%0d expected<=100000", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  function automatic logic [2:0] model(logic [63:0] ea, logic [1:0] md, bit f,
                                       bit o, bit t, logic [3:0] p, bit lv, bit sr);
    bit ss = 0;
    bit gp = (ea[5:0] != 6'd0);
    bit bad;
    logic [64:0] last;
    if (!f || !o || p != 4'd0) return 3'd1;
    if (t) return 3'd2;
    case (md)
      2'd0: begin
        last = {1'b0, ea} + 65'd575;
        if (last > 65'h0FFFF) gp = 1;
      end
      2'd2: begin
        bad = !((ea[63:47] == 17'd0) || (ea[63:47] == '1));
        if (bad) begin if (sr) ss = 1; else gp = 1; end
      end
      default: if (lv) begin if (sr) ss = 1; else gp = 1; end
    endcase
    if (ss) return 3'd3;
    if (gp) return 3'd4;
    return 3'd0;
  endfunction

  task automatic check(string tag, logic [3:0] act, logic [3:0] exp);
    checks = checks + 1;
    if (act !== exp) begin
      failures = failures + 1;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic issue(string tag, logic [63:0] ea, logic [1:0] md, bit f, bit o,
                       bit t, logic [3:0] p, bit lv, bit sr);
    @(negedge clk);
    // idle cycle before this request: valid low, code zero (R1)
    check("R1 idle", {fault_vld_o, fault_code_o}, 4'h0);
    ea_i = ea; mode_i = md; feat_present_i = f; os_enable_i = o;
    task_sw_i = t; pfx_i = p; limit_viol_i = lv; stack_ref_i = sr; req_i = 1'b1;
    @(negedge clk);
    req_i = 1'b0;
    check(tag, {fault_vld_o, fault_code_o}, {1'b1, model(ea, md, f, o, t, p, lv, sr)});
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1 reset", {fault_vld_o, fault_code_o}, 4'h0);

    issue("R13 clean prot", 64'h1000, 2'd1, 1, 1, 0, 4'h0, 0, 0);
    issue("R2 no feature", 64'h1000, 2'd1, 0, 1, 1, 4'h0, 1, 1);
    issue("R3 os off", 64'h1001, 2'd2, 1, 0, 1, 4'h0, 0, 0);
    issue("R4 lock pfx", 64'h1000, 2'd1, 1, 1, 0, 4'h1, 0, 0);
    issue("R4 repne pfx", 64'h1000, 2'd0, 1, 1, 1, 4'h8, 0, 0);
    issue("R5 task switched", 64'h1003, 2'd2, 1, 1, 1, 4'h0, 0, 1);
    issue("R6 misaligned real", 64'h0020, 2'd0, 1, 1, 0, 4'h0, 0, 0);
    issue("R6 misaligned long", 64'h1010, 2'd2, 1, 1, 0, 4'h0, 0, 0);
    issue("R7 real edge ok", 64'hFDC0, 2'd0, 1, 1, 0, 4'h0, 0, 0);
    issue("R7 real edge over", 64'hFE00, 2'd0, 1, 1, 0, 4'h0, 0, 0);
    issue("R7 real wrap", 64'hFFFF_FFFF_FFFF_FFC0, 2'd0, 1, 1, 0, 4'h0, 0, 0);
    issue("R8 canon top ok", 64'h0000_7FFF_FFFF_FFC0, 2'd2, 1, 1, 0, 4'h0, 0, 1);
    issue("R8 canon neg ok", 64'hFFFF_8000_0000_0000, 2'd2, 1, 1, 0, 4'h0, 0, 1);
    issue("R8 noncanon gp", 64'h0000_8000_0000_0000, 2'd2, 1, 1, 0, 4'h0, 0, 0);
    issue("R8 noncanon ss", 64'h0000_8000_0000_0000, 2'd2, 1, 1, 0, 4'h0, 0, 1);
    issue("R10 ss over misalign", 64'h0100_0000_0000_0008, 2'd2, 1, 1, 0, 4'h0, 0, 1);
    issue("R9 limit gp", 64'h2000, 2'd1, 1, 1, 0, 4'h0, 1, 0);
    issue("R9 limit ss", 64'h2000, 2'd1, 1, 1, 0, 4'h0, 1, 1);
    issue("R11 mode3 limit ss", 64'h2000, 2'd3, 1, 1, 0, 4'h0, 1, 1);
    issue("R12 limit ignored real", 64'h2000, 2'd0, 1, 1, 0, 4'h0, 1, 1);
    issue("R12 limit ignored long", 64'h2000, 2'd2, 1, 1, 0, 4'h0, 1, 1);
    issue("R12 canon ignored prot", 64'h0000_8000_0000_0000, 2'd1, 1, 1, 0, 4'h0, 0, 1);
    issue("R12 real stack oob", 64'hFFC0, 2'd0, 1, 1, 0, 4'h0, 0, 1);

    for (int i = 0; i < 3000; i++) begin
      logic [63:0] ea;
      int cls = $urandom % 4;
      case (cls)
        0: ea = {48'd0, 16'($urandom)};
        1: ea = {{17{1'b1}}, 47'({$urandom, $urandom})};
        2: ea = {16'($urandom | 1), 48'({$urandom, $urandom})};
        default: ea = {$urandom, $urandom};
      endcase
      if ($urandom % 2 == 0) ea[5:0] = 6'd0;
      issue("R10 random", ea, 2'($urandom), ($urandom % 8) != 0, ($urandom % 8) != 0,
            ($urandom % 6) == 0, (($urandom % 6) == 0) ? 4'($urandom) : 4'h0,
            ($urandom % 3) == 0, ($urandom % 2) == 0);
    end

    @(negedge clk);
    check("R1 final idle", {fault_vld_o, fault_code_o}, 4'h0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule